// File: doc/BRIEF.md
# Correlation Score Combiner with Programmable Alignment

This block sits after a correlation array and turns its raw score into the value that leaves the device. A programmable bias is added to the score and registered. The sum then passes through a selectable delay of 0 to 15 clocks. The delay lets a unit placed late in a daisy chain line its score up with the units ahead of it. Finally a 13-bit chain input from the previous unit is added to form the 13-bit chain output. All additions wrap modulo 2^13.

When the array is split into two independent correlators, the chain addition is bypassed. The first score, biased and wrapped to 9 bits, goes out on the low 9 bits of the chain output. The second score goes out on the 9-bit side output. In single mode the side output instead carries the reference pattern byte supplied by the array. Each output bus has an active-low enable. The block turns each enable into a registered drive signal for the pad's tri-state buffer, and the data path keeps running while a bus is disabled.

Top module: `corr_cascade_combiner`

## Requirements
- R1: In single mode (`dual_mode`=0), the staged value is (`score_a` + `bias`) mod 8192, registered on the clock edge that samples the inputs.
- R2: With `align_dly`=d (0..15), the value staged at edge t-1-d is the one combined at edge t. The total latency from score input to `chain_out` is therefore d+2 edges, and changing d takes effect on the next edge.
- R3: In single mode, `chain_out` after edge t equals (delayed staged value + `chain_in` sampled at edge t) mod 8192.
- R4: In dual mode (`dual_mode`=1), `chain_out[8:0]` equals (`score_a` + `bias`) mod 512 with the same latency as R2, `chain_out[12:9]` is 0, and `chain_in` has no effect.
- R5: `side_out` after edge t equals (`score_b` + `bias`) mod 512 delayed as in R2, whenever `dual_mode` is 1 at edge t.
- R6: In single mode, `side_out[7:0]` after edge t equals `pattern_in` sampled at edge t, and `side_out[8]` is 0.
- R7: `chain_drive` after edge t equals NOT `chain_oe_n` sampled at edge t. `chain_out` keeps updating while `chain_drive` is 0.
- R8: `side_drive` after edge t equals NOT `side_oe_n` sampled at edge t. `side_out` keeps updating while `side_drive` is 0.
- R9: A synchronous `rst` clears the staging register, every delay register, both outputs and both drive signals to 0. After release, delay slots that have not yet been refilled contribute 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dual_mode | input | 1 | 0: one correlator with chain addition; 1: two independent correlators |
| align_dly | input | 4 | Extra alignment delay in clocks, 0..15 |
| bias | input | 13 | Value added to the score before the delay |
| score_a | input | 9 | Score of the whole array, or of the first correlator in dual mode |
| score_b | input | 9 | Score of the second correlator (used in dual mode) |
| chain_in | input | 13 | Partial sum from the previous unit in the chain |
| pattern_in | input | 8 | Reference pattern byte, routed to the side output in single mode |
| chain_oe_n | input | 1 | Active-low enable for the chain output bus |
| side_oe_n | input | 1 | Active-low enable for the side output bus |
| chain_out | output | 13 | Chain sum, or the first score in dual mode |
| chain_drive | output | 1 | Tri-state drive control for `chain_out`, active high |
| side_out | output | 9 | Second score in dual mode, pattern byte in single mode |
| side_drive | output | 1 | Tri-state drive control for `side_out`, active high |

## Verification
A stuck or mis-shifted delay register shows up at `chain_out` exactly d+2 edges after the affected score enters. The bench streams a fresh score every clock, so a wrong slot in the delay line is caught on the first cycle it reaches the selected tap. A wrong wrap width appears as soon as a score plus bias crosses 8191, or 511 in dual mode; forced full-scale inputs reach those points within a few cycles of each sweep. A delay register that reset does not clear leaks a stale value into the first d+1 outputs after release, and the post-reset run with a nonzero chain input exposes it.

// File: rtl/ccs_pkg.sv
`timescale 1ns/1ps
package ccs_pkg;

  typedef enum logic {
    ROUTE_CASCADE = 1'b0,
    ROUTE_SPLIT   = 1'b1
  } route_e;

  // Sum of two unsigned words kept to the low w bits (modulo 2^w).
  function automatic logic [31:0] wrap_sum(input logic [31:0] x,
                                           input logic [31:0] y,
                                           input int unsigned w);
    logic [31:0] keep;
    keep = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (x + y) & keep;
  endfunction

endpackage

// File: rtl/ccs_offset_stage.sv
`timescale 1ns/1ps
module ccs_offset_stage #(
  parameter int SCORE_W = 9,
  parameter int CAS_W   = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dual_mode,
  input  logic [SCORE_W-1:0] score_a,
  input  logic [SCORE_W-1:0] score_b,
  input  logic [CAS_W-1:0]   bias,
  output logic [CAS_W-1:0]   stage_a,
  output logic [SCORE_W-1:0] stage_b
);
  import ccs_pkg::*;

  route_e               route;
  logic [CAS_W-1:0]     next_a;
  logic [SCORE_W-1:0]   next_b;

  assign route = route_e'(dual_mode);

  always_comb begin
    if (route == ROUTE_SPLIT)
      next_a = CAS_W'(wrap_sum(32'(score_a), 32'(bias), SCORE_W));
    else
      next_a = CAS_W'(wrap_sum(32'(score_a), 32'(bias), CAS_W));
    next_b = SCORE_W'(wrap_sum(32'(score_b), 32'(bias), SCORE_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_a <= '0;
      stage_b <= '0;
    end else begin
      stage_a <= next_a;
      stage_b <= next_b;
    end
  end

endmodule

// File: rtl/ccs_delay_line.sv
`timescale 1ns/1ps
module ccs_delay_line #(
  parameter int W     = 22,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     din,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     tap
);
  localparam int MAX_DLY = (1 << SEL_W) - 1;

  logic [MAX_DLY:0][W-1:0] taps;

  assign taps[0] = din;

  for (genvar i = 0; i < MAX_DLY; i++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= taps[i];
    end
    assign taps[i+1] = q;
  end

  assign tap = taps[sel];

endmodule

// File: rtl/ccs_output_stage.sv
`timescale 1ns/1ps
module ccs_output_stage #(
  parameter int SCORE_W = 9,
  parameter int CAS_W   = 13,
  parameter int REF_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dual_mode,
  input  logic [CAS_W-1:0]   tap_a,
  input  logic [SCORE_W-1:0] tap_b,
  input  logic [CAS_W-1:0]   chain_in,
  input  logic [REF_W-1:0]   pattern_in,
  input  logic               chain_oe_n,
  input  logic               side_oe_n,
  output logic [CAS_W-1:0]   chain_out,
  output logic               chain_drive,
  output logic [SCORE_W-1:0] side_out,
  output logic               side_drive
);
  import ccs_pkg::*;

  route_e             route;
  logic [CAS_W-1:0]   next_chain;
  logic [SCORE_W-1:0] next_side;

  assign route = route_e'(dual_mode);

  always_comb begin
    if (route == ROUTE_SPLIT) begin
      next_chain = CAS_W'(tap_a[SCORE_W-1:0]);
      next_side  = tap_b;
    end else begin
      next_chain = CAS_W'(wrap_sum(32'(tap_a), 32'(chain_in), CAS_W));
      next_side  = SCORE_W'(pattern_in);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_out   <= '0;
      side_out    <= '0;
      chain_drive <= 1'b0;
      side_drive  <= 1'b0;
    end else begin
      chain_out   <= next_chain;
      side_out    <= next_side;
      chain_drive <= ~chain_oe_n;
      side_drive  <= ~side_oe_n;
    end
  end

endmodule

// File: rtl/corr_cascade_combiner.sv
`timescale 1ns/1ps
module corr_cascade_combiner #(
  parameter int SCORE_W = 9,
  parameter int CAS_W   = 13,
  parameter int REF_W   = 8,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dual_mode,
  input  logic [SEL_W-1:0]   align_dly,
  input  logic [CAS_W-1:0]   bias,
  input  logic [SCORE_W-1:0] score_a,
  input  logic [SCORE_W-1:0] score_b,
  input  logic [CAS_W-1:0]   chain_in,
  input  logic [REF_W-1:0]   pattern_in,
  input  logic               chain_oe_n,
  input  logic               side_oe_n,
  output logic [CAS_W-1:0]   chain_out,
  output logic               chain_drive,
  output logic [SCORE_W-1:0] side_out,
  output logic               side_drive
);
  localparam int LANE_W = CAS_W + SCORE_W;

  // Named internal points, also used by the bound checker.
  logic [CAS_W-1:0]   stage_a;
  logic [SCORE_W-1:0] stage_b;
  logic [CAS_W-1:0]   tap_a;
  logic [SCORE_W-1:0] tap_b;
  logic [LANE_W-1:0]  lane_in;
  logic [LANE_W-1:0]  lane_tap;

  ccs_offset_stage #(.SCORE_W(SCORE_W), .CAS_W(CAS_W)) u_offset (
    .clk      (clk),
    .rst      (rst),
    .dual_mode(dual_mode),
    .score_a  (score_a),
    .score_b  (score_b),
    .bias     (bias),
    .stage_a  (stage_a),
    .stage_b  (stage_b)
  );

  assign lane_in = {stage_a, stage_b};

  ccs_delay_line #(.W(LANE_W), .SEL_W(SEL_W)) u_delay (
    .clk(clk),
    .rst(rst),
    .din(lane_in),
    .sel(align_dly),
    .tap(lane_tap)
  );

  assign tap_a = lane_tap[LANE_W-1 -: CAS_W];
  assign tap_b = lane_tap[SCORE_W-1:0];

  ccs_output_stage #(.SCORE_W(SCORE_W), .CAS_W(CAS_W), .REF_W(REF_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .dual_mode  (dual_mode),
    .tap_a      (tap_a),
    .tap_b      (tap_b),
    .chain_in   (chain_in),
    .pattern_in (pattern_in),
    .chain_oe_n (chain_oe_n),
    .side_oe_n  (side_oe_n),
    .chain_out  (chain_out),
    .chain_drive(chain_drive),
    .side_out   (side_out),
    .side_drive (side_drive)
  );

endmodule

// File: rtl/ccs_checker.sv
`timescale 1ns/1ps
module ccs_checker #(
  parameter int SCORE_W = 9,
  parameter int CAS_W   = 13,
  parameter int REF_W   = 8,
  parameter int SEL_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               dual_mode,
  input logic [SEL_W-1:0]   align_dly,
  input logic [CAS_W-1:0]   bias,
  input logic [SCORE_W-1:0] score_a,
  input logic [CAS_W-1:0]   chain_in,
  input logic [REF_W-1:0]   pattern_in,
  input logic               chain_oe_n,
  input logic               side_oe_n,
  input logic [CAS_W-1:0]   chain_out,
  input logic               chain_drive,
  input logic [SCORE_W-1:0] side_out,
  input logic               side_drive,
  input logic [CAS_W-1:0]   stage_a,
  input logic [CAS_W-1:0]   tap_a,
  input logic [SCORE_W-1:0] tap_b
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    (started && $past(rst)) |-> (chain_out == '0 && side_out == '0 && !chain_drive && !side_drive)); // R9

  AST_OFFSET_SUM: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && !$past(dual_mode)) |->
      (stage_a == CAS_W'($past(score_a) + $past(bias)))); // R1

  AST_DELAY_ONE: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && align_dly == SEL_W'(1)) |-> (tap_a == $past(stage_a))); // R2

  AST_CHAIN_SUM: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && !$past(dual_mode)) |->
      (chain_out == CAS_W'($past(tap_a) + $past(chain_in)))); // R3

  AST_SPLIT_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && $past(dual_mode)) |->
      (chain_out[CAS_W-1:SCORE_W] == '0 && chain_out[SCORE_W-1:0] == $past(tap_a[SCORE_W-1:0]))); // R4

  AST_SPLIT_SIDE: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && $past(dual_mode)) |-> (side_out == $past(tap_b))); // R5

  AST_SIDE_PATTERN: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && !$past(dual_mode)) |->
      (side_out == SCORE_W'($past(pattern_in)))); // R6

  AST_CHAIN_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst)) |-> (chain_drive == !$past(chain_oe_n))); // R7

  AST_SIDE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst)) |-> (side_drive == !$past(side_oe_n))); // R8

endmodule

bind corr_cascade_combiner ccs_checker #(
  .SCORE_W(SCORE_W), .CAS_W(CAS_W), .REF_W(REF_W), .SEL_W(SEL_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dual_mode  (dual_mode),
  .align_dly  (align_dly),
  .bias       (bias),
  .score_a    (score_a),
  .chain_in   (chain_in),
  .pattern_in (pattern_in),
  .chain_oe_n (chain_oe_n),
  .side_oe_n  (side_oe_n),
  .chain_out  (chain_out),
  .chain_drive(chain_drive),
  .side_out   (side_out),
  .side_drive (side_drive),
  .stage_a    (stage_a),
  .tap_a      (tap_a),
  .tap_b      (tap_b)
);

// File: tb/tb_corr_cascade_combiner.sv
`timescale 1ns/1ps
module tb_corr_cascade_combiner;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dual_mode = 1'b0;
  logic [3:0]  align_dly = '0;
  logic [12:0] bias = '0;
  logic [8:0]  score_a = '0;
  logic [8:0]  score_b = '0;
  logic [12:0] chain_in = '0;
  logic [7:0]  pattern_in = '0;
  logic        chain_oe_n = 1'b1;
  logic        side_oe_n = 1'b1;
  logic [12:0] chain_out;
  logic        chain_drive;
  logic [8:0]  side_out;
  logic        side_drive;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int hist_a [0:16];
  int hist_b [0:16];

  always #10 clk = ~clk;  // 50 MHz

  corr_cascade_combiner dut (
    .clk(clk), .rst(rst), .dual_mode(dual_mode), .align_dly(align_dly),
    .bias(bias), .score_a(score_a), .score_b(score_b), .chain_in(chain_in),
    .pattern_in(pattern_in), .chain_oe_n(chain_oe_n), .side_oe_n(side_oe_n),
    .chain_out(chain_out), .chain_drive(chain_drive),
    .side_out(side_out), .side_drive(side_drive)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: model from the inputs now applied, then compare after the edge.
  task automatic tick();
    int sa, sb, ec, es, ecd, esd;
    string tc, ts;
    if (rst) begin
      for (int k = 16; k > 0; k--) begin hist_a[k] = hist_a[k-1]; hist_b[k] = hist_b[k-1]; end
      hist_a[0] = 0; hist_b[0] = 0;
      for (int k = 0; k <= 16; k++) begin hist_a[k] = 0; hist_b[k] = 0; end
      ec = 0; es = 0; ecd = 0; esd = 0; tc = "R9 chain"; ts = "R9 side";
    end else begin
      sa = dual_mode ? (int'(score_a) + int'(bias)) % 512 : (int'(score_a) + int'(bias)) % 8192;
      sb = (int'(score_b) + int'(bias)) % 512;
      for (int k = 16; k > 0; k--) begin hist_a[k] = hist_a[k-1]; hist_b[k] = hist_b[k-1]; end
      hist_a[0] = sa; hist_b[0] = sb;
      if (dual_mode) begin
        ec = hist_a[int'(align_dly) + 1] % 512;
        es = hist_b[int'(align_dly) + 1];
        tc = "R4 chain"; ts = "R5 side";
      end else begin
        ec = (hist_a[int'(align_dly) + 1] + int'(chain_in)) % 8192;
        es = int'(pattern_in);
        tc = "R1 R2 R3 chain"; ts = "R6 side";
      end
      ecd = chain_oe_n ? 0 : 1;
      esd = side_oe_n ? 0 : 1;
    end
    @(posedge clk);
    #2;
    check(int'(chain_out) == ec, tc, int'(chain_out), ec);
    check(int'(side_out) == es, ts, int'(side_out), es);
    check(int'(chain_drive) == ecd, rst ? "R9 chain_drive" : "R7 chain_drive", int'(chain_drive), ecd);
    check(int'(side_drive) == esd, rst ? "R9 side_drive" : "R8 side_drive", int'(side_drive), esd);
    @(negedge clk);
  endtask

  task automatic drive_random(input bit force_max);
    score_a    = force_max ? 9'h1FF : 9'($urandom_range(0, 511));
    score_b    = force_max ? 9'h1FF : 9'($urandom_range(0, 511));
    bias       = force_max ? 13'h1FFF : 13'($urandom_range(0, 8191));
    chain_in   = force_max ? 13'h1FFF : 13'($urandom_range(0, 8191));
    pattern_in = 8'($urandom_range(0, 255));
    chain_oe_n = 1'($urandom_range(0, 1));
    side_oe_n  = 1'($urandom_range(0, 1));
  endtask

  initial begin
    for (int k = 0; k <= 16; k++) begin hist_a[k] = 0; hist_b[k] = 0; end
    @(negedge clk);
    // R9: reset state
    for (int i = 0; i < 3; i++) begin drive_random(0); tick(); end
    rst = 1'b0;
    // R1 R2 R3 R6: single mode, every delay setting
    for (int d = 0; d < 16; d++) begin
      align_dly = 4'(d);
      for (int i = 0; i < 40; i++) begin drive_random(i % 8 == 3); tick(); end
    end
    // R4 R5: dual mode, every delay setting, chain_in random and ignored
    dual_mode = 1'b1;
    for (int d = 0; d < 16; d++) begin
      align_dly = 4'(d);
      for (int i = 0; i < 24; i++) begin drive_random(i % 6 == 2); tick(); end
    end
    // R2 R7 R8: mode, delay and enables changing every cycle
    for (int i = 0; i < 2000; i++) begin
      dual_mode = 1'($urandom_range(0, 1));
      align_dly = 4'($urandom_range(0, 15));
      drive_random(i % 13 == 0);
      tick();
    end
    // R9: mid-run reset, then refill with a nonzero chain input at maximum delay
    dual_mode = 1'b0;
    align_dly = 4'd15;
    rst = 1'b1;
    for (int i = 0; i < 2; i++) begin drive_random(0); tick(); end
    rst = 1'b0;
    for (int i = 0; i < 40; i++) begin drive_random(0); tick(); end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule